// File: doc/BRIEF.md
# Oversampled Serial Receive Channel with Flagged FIFO

This block is the receive half of a 16550-style serial port. It takes the asynchronous serial line, synchronises it, and samples it at sixteen times the bit rate, as set by an external one-cycle strobe. A falling edge starts a character only if the line is still low at the middle of the start bit. The channel then collects 5 to 8 data bits, least significant bit first, takes an optional even or odd parity bit, and checks the stop bit. Each finished character goes into a 16-entry FIFO. The parity-error, framing-error and break flags of that character are stored in the same entry.

The host side pops entries one at a time and sees the oldest entry at the head. Two signals follow the FIFO fill level against a selectable threshold. One is a level-style data-available flag. The other is an active-low receive-ready output for DMA-style transfers: it stays asserted until the FIFO has drained completely. A character that arrives while the FIFO is full is lost and sets a sticky overrun flag, which a line-status read clears.

Top module: `serial_rx_channel`

## Requirements
- R1: `width_i` selects the data bits per character (00=5, 01=6, 10=7, 11=8). Bits are received least significant first and stored right-aligned in `data_o`, with unused upper bits zero.
- R2: With `par_en_i`=1 a parity bit follows the data. It is even when `par_odd_i`=0 and odd when `par_odd_i`=1. A mismatch sets the entry's `perr_o`. With `par_en_i`=0 no parity bit is expected and `perr_o` is 0.
- R3: A low pulse on `rxd_i` that has returned high at the start-bit midpoint (8 oversample ticks after detection) is discarded, and no entry is written.
- R4: A stop bit sampled low sets the entry's `ferr_o`. The receiver then waits for the line to go high before it looks for a new start bit.
- R5: A line held low through a whole character, including parity and stop, stores exactly one entry with data 0, `brk_o`=1, `ferr_o`=1 and `perr_o`=0. No further entry is stored until the line returns high.
- R6: The FIFO holds up to 16 entries in arrival order. Each entry's flags stay with its data. `level_o` gives the entry count and `empty_o` is 1 when the count is 0.
- R7: A character that completes while the FIFO holds 16 entries is discarded and sets `overrun_o` on the next cycle. `overrun_o` stays set until a `lsr_rd_i` pulse clears it.
- R8: `avail_o` is 1 exactly when `level_o` is at or above the threshold chosen by `trig_sel_i` (00=1, 01=4, 10=8, 11=14).
- R9: `rx_ready_no` goes low one cycle after `avail_o` is 1. It goes high again one cycle after the FIFO is empty, and holds its value in between.
- R10: `pop_i` while the FIFO is empty has no effect on `level_o` or on the stored entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | Oversample strobe, 16 per bit time |
| rxd_i | input | 1 | Serial line, idle high |
| width_i | input | 2 | Data-bit count select |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | Odd parity when 1, even when 0 |
| trig_sel_i | input | 2 | FIFO threshold select |
| pop_i | input | 1 | Remove head entry |
| lsr_rd_i | input | 1 | Line-status read, clears overrun |
| data_o | output | 8 | Head entry data |
| perr_o | output | 1 | Head entry parity error |
| ferr_o | output | 1 | Head entry framing error |
| brk_o | output | 1 | Head entry break |
| empty_o | output | 1 | FIFO empty |
| level_o | output | 5 | FIFO entry count |
| avail_o | output | 1 | Level at or above threshold |
| overrun_o | output | 1 | Sticky overrun |
| rx_ready_no | output | 1 | DMA receive-ready, active low |

## Verification
The hardest state to reach is a full FIFO that receives one more character. Sixteen complete serial frames have to be delivered with no pop between them, and the overrun clear then has to be shown separately from the drop. The stimulus fills the FIFO while the threshold is 4, changes the threshold during the fill and the drain, and sends a seventeenth frame. The per-cycle model tracks the stored entries, the threshold flag and the hysteresis of the ready output all through the fill and the drain. Break and false-start cases are separate line patterns that are held low for a long time or only briefly.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;
  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
    logic       brk;
  } rx_word_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD
  } rx_state_e;

  function automatic int trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/rx_bit_sampler.sv
`timescale 1ns/1ps
module rx_bit_sampler
  import rxf_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     rxd_i,
  input  logic [1:0] width_i,
  input  logic     par_en_i,
  input  logic     par_odd_i,
  output rx_word_t word_o,
  output logic     valid_o
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2 - 1;

  logic [1:0]  sync_q;
  logic        rx_s;
  rx_state_e   state_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]  bit_idx_q;
  logic [7:0]  shreg_q;
  logic        zeros_q;
  logic        par_acc_q;
  logic        valid_q;
  rx_word_t    word_q;
  logic [2:0]  last_idx;
  logic        bit_end;
  logic        stop_brk;

  assign rx_s     = sync_q[1];
  assign last_idx = 3'd4 + {1'b0, width_i};
  assign bit_end  = tick_i && (cnt_q == CW'(OSR - 1));
  assign stop_brk = zeros_q && !rx_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      cnt_q     <= '0;
      bit_idx_q <= '0;
      shreg_q   <= '0;
      zeros_q   <= 1'b0;
      par_acc_q <= 1'b0;
      valid_q   <= 1'b0;
      word_q    <= '0;
    end else begin
      valid_q <= 1'b0;
      if (tick_i && state_q != S_IDLE && state_q != S_HOLD)
        cnt_q <= cnt_q + 1'b1;
      unique case (state_q)
        S_IDLE: if (tick_i && !rx_s) begin
          state_q <= S_START;
          cnt_q   <= '0;
        end
        S_START: if (tick_i && cnt_q == CW'(MID)) begin
          cnt_q     <= '0;
          bit_idx_q <= '0;
          shreg_q   <= '0;
          zeros_q   <= 1'b1;
          par_acc_q <= 1'b0;
          state_q   <= rx_s ? S_IDLE : S_DATA;  // false start check
        end
        S_DATA: if (bit_end) begin
          shreg_q[bit_idx_q] <= rx_s;
          par_acc_q <= par_acc_q ^ rx_s;
          zeros_q   <= zeros_q & ~rx_s;
          bit_idx_q <= bit_idx_q + 1'b1;
          if (bit_idx_q == last_idx) state_q <= par_en_i ? S_PAR : S_STOP;
        end
        S_PAR: if (bit_end) begin
          par_acc_q <= par_acc_q ^ rx_s;
          zeros_q   <= zeros_q & ~rx_s;
          state_q   <= S_STOP;
        end
        S_STOP: if (bit_end) begin
          valid_q     <= 1'b1;
          word_q.data <= stop_brk ? 8'h00 : shreg_q;
          word_q.perr <= par_en_i && !stop_brk && (par_acc_q ^ par_odd_i);
          word_q.ferr <= !rx_s;
          word_q.brk  <= stop_brk;
          state_q     <= rx_s ? S_IDLE : S_HOLD;
        end
        S_HOLD: if (rx_s) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

  p_break_word_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && word_o.brk) |-> (word_o.data == 8'h00 && word_o.ferr && !word_o.perr));
  p_hold_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_HOLD && $past(state_q == S_HOLD)) |-> !valid_o);
  p_false_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_START && tick_i && cnt_q == CW'(MID) && rx_s) |=> (state_q == S_IDLE && !valid_o));
endmodule

// File: rtl/rx_flag_fifo.sv
`timescale 1ns/1ps
module rx_flag_fifo #(
  parameter int W     = 11,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic [LW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [LW-1:0] count_q;
  logic          do_push, do_pop;

  assign full_o  = (count_q == LW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) if (do_push) mem[wr_ptr_q] <= din_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign dout_o  = mem[rd_ptr_q];
  assign count_o = count_q;

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= LW'(DEPTH));
  p_pop_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> (count_q == '0 && $stable(rd_ptr_q)));
  p_full_push_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> ($stable(wr_ptr_q) && full_o));
endmodule

// File: rtl/rx_trigger.sv
`timescale 1ns/1ps
module rx_trigger
  import rxf_pkg::*;
#(
  parameter int LW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] count_i,
  input  logic [1:0]    sel_i,
  output logic          avail_o,
  output logic          rdy_no
);
  logic [LW-1:0] thr;
  logic          rdy_n_q;

  assign thr     = LW'(trig_level(sel_i));
  assign avail_o = (count_i >= thr);

  // hysteresis: assert on threshold, release only when drained
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdy_n_q <= 1'b1;
    else if (avail_o)         rdy_n_q <= 1'b0;
    else if (count_i == '0)   rdy_n_q <= 1'b1;
  end

  assign rdy_no = rdy_n_q;

  p_rdy_assert_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avail_o |=> !rdy_no);
  p_rdy_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == '0) |=> rdy_no);
endmodule

// File: rtl/serial_rx_channel.sv
`timescale 1ns/1ps
module serial_rx_channel
  import rxf_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick16_i,
  input  logic          rxd_i,
  input  logic [1:0]    width_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic [1:0]    trig_sel_i,
  input  logic          pop_i,
  input  logic          lsr_rd_i,
  output logic [7:0]    data_o,
  output logic          perr_o,
  output logic          ferr_o,
  output logic          brk_o,
  output logic          empty_o,
  output logic [LW-1:0] level_o,
  output logic          avail_o,
  output logic          overrun_o,
  output logic          rx_ready_no
);
  localparam int W = $bits(rx_word_t);

  rx_word_t      rx_word, head;
  logic          rx_valid, full;
  logic          ovr_q;
  logic [LW-1:0] count;

  rx_bit_sampler #(.OSR(OSR)) u_sampler (
    .clk_i, .rst_ni,
    .tick_i   (tick16_i),
    .rxd_i,
    .width_i,
    .par_en_i,
    .par_odd_i,
    .word_o   (rx_word),
    .valid_o  (rx_valid)
  );

  rx_flag_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i  (rx_valid),
    .din_i   (rx_word),
    .pop_i,
    .dout_o  (head),
    .count_o (count),
    .full_o  (full),
    .empty_o
  );

  rx_trigger #(.LW(LW)) u_trig (
    .clk_i, .rst_ni,
    .count_i (count),
    .sel_i   (trig_sel_i),
    .avail_o,
    .rdy_no  (rx_ready_no)
  );

  // set wins over a same-cycle status read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ovr_q <= 1'b0;
    else if (rx_valid && full)  ovr_q <= 1'b1;
    else if (lsr_rd_i)          ovr_q <= 1'b0;
  end

  assign overrun_o = ovr_q;
  assign level_o   = count;
  assign data_o    = head.data;
  assign perr_o    = head.perr;
  assign ferr_o    = head.ferr;
  assign brk_o     = head.brk;

  p_ovr_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid && full) |=> overrun_o);
  p_ovr_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && !(rx_valid && full)) |=> !overrun_o);
  p_ovr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !lsr_rd_i) |=> overrun_o);
endmodule

// File: tb/serial_rx_channel_tb.sv
`timescale 1ns/1ps
module serial_rx_channel_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] width = 2'b11;
  logic       par_en = 1'b0, par_odd = 1'b0;
  logic [1:0] trig = 2'b00;
  logic       pop = 1'b0, lsr_rd = 1'b0;
  logic [7:0] data_o;
  logic       perr_o, ferr_o, brk_o, empty_o, avail_o, overrun_o, rdy_n;
  logic [4:0] level_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [10:0] pending[$];
  logic [10:0] stored[$];
  bit   model_rdy_n = 1;
  bit   pop_hit = 0;

  always #5 clk = ~clk;
  always @(posedge clk) tick <= rst_n ? ~tick : 1'b0;

  serial_rx_channel u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick), .rxd_i(rxd),
    .width_i(width), .par_en_i(par_en), .par_odd_i(par_odd),
    .trig_sel_i(trig), .pop_i(pop), .lsr_rd_i(lsr_rd),
    .data_o, .perr_o, .ferr_o, .brk_o, .empty_o, .level_o,
    .avail_o, .overrun_o, .rx_ready_no(rdy_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int thr_of(input logic [1:0] s);
    case (s)
      2'b00: return 1;  2'b01: return 4;  2'b10: return 8;  default: return 14;
    endcase
  endfunction

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  always @(posedge clk) pop_hit <= pop && !empty_o;

  // per-cycle reference comparison (R6, R8, R9)
  always @(negedge clk) begin
    if (rst_n) begin
      if (pop_hit && stored.size() > 0) void'(stored.pop_front());
      if (int'(level_o) > stored.size()) begin
        if (pending.size() > 0) stored.push_back(pending.pop_front());
        else chk(0, "R6 unexpected entry", level_o, stored.size());
      end
      chk(int'(level_o) == stored.size(), "R6 level", level_o, stored.size());
      chk(empty_o == (stored.size() == 0), "R6 empty", empty_o, stored.size() == 0);
      if (!empty_o && stored.size() > 0)
        chk({data_o, perr_o, ferr_o, brk_o} == stored[0], "R6 head",
            {data_o, perr_o, ferr_o, brk_o}, stored[0]);
      chk(avail_o == (int'(level_o) >= thr_of(trig)), "R8 avail", avail_o,
          int'(level_o) >= thr_of(trig));
      chk(rdy_n == model_rdy_n, "R9 ready", rdy_n, model_rdy_n);
      if (int'(level_o) >= thr_of(trig)) model_rdy_n = 0;
      else if (level_o == 0)             model_rdy_n = 1;
    end
  end

  task automatic line_bit(input logic v);
    rxd = v;
    clks(32);
  endtask

  // sends one frame with the current format; expect=0 means the entry is dropped
  task automatic send(input logic [7:0] d, input bit bad_par, input bit stop, input bit expect_it);
    int nb = 5 + int'(width);
    logic par;
    logic [7:0] m;
    m = d & 8'((1 << nb) - 1);
    par = (^m) ^ par_odd ^ bad_par;
    if (expect_it) pending.push_back({m, par_en & bad_par, ~stop, 1'b0});
    line_bit(1'b0);
    for (int i = 0; i < nb; i++) line_bit(m[i]);
    if (par_en) line_bit(par);
    line_bit(stop);
    rxd = 1'b1;
    clks(64);
  endtask

  task automatic pop_expect(input logic [10:0] e, input string req);
    chk({data_o, perr_o, ferr_o, brk_o} == e, req, {data_o, perr_o, ferr_o, brk_o}, e);
    pop = 1'b1;
    clks(1);
    pop = 1'b0;
    clks(1);
  endtask

  task automatic drain();
    while (!empty_o) begin
      pop = 1'b1; clks(1); pop = 1'b0; clks(1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int lvl;
    clks(4);
    rst_n = 1'b1;
    clks(2);
    chk(empty_o == 1 && level_o == 0, "R6 reset empty", level_o, 0);
    chk(overrun_o == 0, "R7 reset overrun", overrun_o, 0);
    chk(rdy_n == 1 && avail_o == 0, "R9 reset ready", rdy_n, 1);
    clks(40);

    // R1: 8 data bits, no parity
    width = 2'b11; par_en = 0;
    send(8'hA5, 0, 1, 1);
    pop_expect({8'hA5, 3'b000}, "R1 8-bit byte");

    // R2: 7 bits even parity, good then bad
    width = 2'b10; par_en = 1; par_odd = 0;
    send(8'h55, 0, 1, 1);
    send(8'h2A, 1, 1, 1);
    pop_expect({8'h55, 3'b000}, "R2 even parity ok");
    pop_expect({8'h2A, 3'b100}, "R2 even parity error");

    // R1/R2: 5 bits odd parity, upper bits masked
    width = 2'b00; par_odd = 1;
    send(8'hF3, 0, 1, 1);
    send(8'h0E, 1, 1, 1);
    pop_expect({8'h13, 3'b000}, "R1 5-bit masked");
    pop_expect({8'h0E, 3'b100}, "R2 odd parity error");

    // R1: 6 bits, no parity
    width = 2'b01; par_en = 0;
    send(8'h3F, 0, 1, 1);
    pop_expect({8'h3F, 3'b000}, "R1 6-bit byte");

    // R3: glitch shorter than half a bit
    lvl = level_o;
    rxd = 1'b0; clks(6); rxd = 1'b1;
    clks(32 * 12);
    chk(int'(level_o) == lvl, "R3 glitch discarded", level_o, lvl);

    // R4: stop bit low, line held low a while then high
    width = 2'b11;
    send(8'h3C, 0, 0, 1);
    pop_expect({8'h3C, 3'b010}, "R4 framing error");

    // R5: break held for 14 bit times
    lvl = level_o;
    pending.push_back({8'h00, 3'b011});
    rxd = 1'b0; clks(32 * 14); rxd = 1'b1; clks(32 * 3);
    chk(int'(level_o) == lvl + 1, "R5 single break entry", level_o, lvl + 1);
    pop_expect({8'h00, 3'b011}, "R5 break entry");
    send(8'h81, 0, 1, 1);
    pop_expect({8'h81, 3'b000}, "R5 reception after break");
    drain();
    clks(2);
    chk(rdy_n == 1, "R9 released when empty", rdy_n, 1);

    // R10: pop on empty
    pop = 1'b1; clks(1); pop = 1'b0; clks(2);
    chk(level_o == 0 && empty_o == 1, "R10 pop on empty", level_o, 0);

    // R8/R9/R7: fill to full with threshold 4
    trig = 2'b01;
    for (int i = 0; i < 16; i++) begin
      send(8'h10 + 8'(i), 0, 1, 1);
      if (i == 2) chk(avail_o == 0 && rdy_n == 1, "R8 below 4", avail_o, 0);
      if (i == 3) chk(avail_o == 1 && rdy_n == 0, "R9 at threshold 4", rdy_n, 0);
      if (i == 9) trig = 2'b10;
    end
    trig = 2'b11;
    clks(1);
    chk(avail_o == 1, "R8 threshold 14 at 16", avail_o, 1);
    send(8'hEE, 0, 1, 0);
    chk(level_o == 16, "R7 dropped byte", level_o, 16);
    chk(overrun_o == 1, "R7 overrun set", overrun_o, 1);
    clks(20);
    chk(overrun_o == 1, "R7 overrun sticky", overrun_o, 1);
    lsr_rd = 1'b1; clks(1); lsr_rd = 1'b0; clks(1);
    chk(overrun_o == 0, "R7 overrun cleared", overrun_o, 0);

    pop_expect({8'h10, 3'b000}, "R6 order head");
    pop_expect({8'h11, 3'b000}, "R6 order second");
    pop_expect({8'h12, 3'b000}, "R6 order third");
    chk(level_o == 13 && avail_o == 0, "R8 13 below 14", avail_o, 0);
    chk(rdy_n == 0, "R9 holds below threshold", rdy_n, 0);
    trig = 2'b10; clks(1);
    chk(avail_o == 1, "R8 13 above 8", avail_o, 1);
    trig = 2'b00;
    drain();
    clks(2);
    chk(rdy_n == 1 && avail_o == 0, "R9 released after drain", rdy_n, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule